// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software programs two address registers, a down-counting item count and a configuration word through a small register port. The channel then moves data items one at a time. Each item is a read from the source address followed by a write to the destination address, both issued on a single-beat bus master. The bus holds each phase until the slave returns ready.

Items are started in one of two ways. A peripheral can pace the channel with a request/acknowledge handshake, which allows peripheral-to-memory, memory-to-peripheral or peripheral-to-peripheral moves. Alternatively, a self-trigger bit lets the channel start items on its own, for memory-to-memory or register-to-register copies. A direction bit selects which of the two address/size/increment triplets is the source and which is the destination.

When the count runs out, the channel either raises a sticky completion flag or, in circular mode, reloads its programmed values and keeps going. Enabling self-trigger together with circular mode is refused and raises a configuration-error flag.

Top module: `dma_xfer_chan`

## Requirements
- R1: Register select codes, for both write (`reg_sel`) and readback (`reg_rsel`), are: 0 = configuration, 1 = peripheral-side address, 2 = memory-side address, 3 = item count. Readback of 1, 2 and 3 returns the current (advancing) values. While the enable bit is 1 or an item is in flight, every register write is ignored, with one exception: a configuration write while enabled takes only its bit 0, so it can clear enable.
- R2: Configuration bits [5:4] give the peripheral-side size and bits [7:6] the memory-side size (00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 32 bits). Bit 8 is the peripheral-side increment and bit 9 the memory-side increment. When an increment bit is set, that side's address advances by its own size in bytes after each item.
- R3: Configuration bit 1 is the direction. With direction 1, the memory-side triplet is the source and the peripheral-side triplet the destination. With direction 0, the roles are swapped.
- R4: With self-trigger (configuration bit 3) set and enable (bit 0) set, items run one after another until the count is zero, with no peripheral request.
- R5: With self-trigger clear, each item waits for `periph_req`. Exactly one item is done per request, and `periph_ack` pulses for one cycle in the cycle its write completes. No item starts without a request.
- R6: When the count reaches zero in non-circular mode, no further bus cycles are issued. `tc_flag` is set and stays set until `flag_clr[0]` is pulsed.
- R7: With circular (configuration bit 2) set and self-trigger clear, reaching zero reloads the count and both addresses with their programmed values, `tc_flag` is not set, and the channel keeps serving requests.
- R8: A configuration write with enable, circular and self-trigger all set leaves enable at 0, sets `cfg_err`, and issues no bus cycle. `flag_clr[1]` clears `cfg_err`.
- R9: Write data is the read data zero-extended or truncated to the narrower of the two sizes. Data is right-aligned on the bus.
- R10: Clearing enable while an item is in flight lets that item finish (its write is issued and the count drops by one), and no further item starts.
- R11: After reset, the configuration and count read as 0, both flags are 0 and `bus_valid` is 0.
- R12: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write` and `bus_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rsel | input | 2 | Register select for readback |
| reg_rdata | output | 32 | Readback data (combinational) |
| flag_clr | input | 2 | bit 0 clears tc_flag, bit 1 clears cfg_err |
| tc_flag | output | 1 | Transfer-complete flag |
| cfg_err | output | 1 | Configuration-error flag |
| periph_req | input | 1 | Peripheral request |
| periph_ack | output | 1 | One-cycle acknowledge per paced item |
| bus_valid | output | 1 | Bus phase active |
| bus_write | output | 1 | 1 = write phase, 0 = read phase |
| bus_addr | output | AW | Bus address |
| bus_size | output | 2 | Bus access size (00/01/10) |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Slave completes the current phase |
| bus_rdata | input | 32 | Read data |

## Verification
The bench walks a table of direction, size and increment combinations. It checks every write address and data word against a model of the mapping and the width conversion. A swapped triplet, or an increment by the wrong side's size, therefore shows up as a wrong address, and a missing mask shows up as extra upper bits in the data. Directed cases look at the moments where state changes:
- An abort while a read is stalled. A design that drops the item, or starts another, shows the wrong write count.
- A circular wrap, where a missing reload shows up as a run-away address or a false completion flag.
- The forbidden mode pair, where a design that starts anyway issues bus cycles.
- Register writes while enabled, where a design that accepts them shows changed readback.

// File: rtl/dma_chan_pkg.sv
// Shared types and helpers for the single DMA channel.
// Assumes the configuration word fits the low 10 bits of the register data.
package dma_chan_pkg;

    // Configuration word, msb first; bit 0 is the enable
    typedef struct packed {
        logic       minc;
        logic       pinc;
        logic [1:0] msize;
        logic [1:0] psize;
        logic       selftrig;
        logic       circ;
        logic       dir;
        logic       en;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_t;

    localparam logic [1:0] SEL_CFG = 2'd0;
    localparam logic [1:0] SEL_PA  = 2'd1;
    localparam logic [1:0] SEL_MA  = 2'd2;
    localparam logic [1:0] SEL_CNT = 2'd3;

    // Byte count of one item for a size code; reserved code acts as 32 bits
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Data mask for a size code
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'b00:   return 32'h0000_00FF;
            2'b01:   return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
// Register file of the channel: configuration, programmed and current
// addresses, programmed and current count, completion and error flags.
// Assumes item_done pulses for one cycle per finished item, and that the
// engine never reports busy while it is idle.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic [1:0]    flag_clr,
    input  logic          busy,
    input  logic          item_done,
    output chan_cfg_t     cfg_o,
    output logic [AW-1:0] pa_cur_o,
    output logic [AW-1:0] ma_cur_o,
    output logic [CW-1:0] cnt_cur_o,
    output logic          tc_o,
    output logic          err_o
);
    localparam int CFG_W = $bits(chan_cfg_t);

    chan_cfg_t     cfg_q;
    logic [AW-1:0] pa_init, ma_init, pa_cur, ma_cur;
    logic [CW-1:0] cnt_init, cnt_cur;
    logic          tc_q, err_q;
    logic          locked;
    logic [AW-1:0] pa_step, ma_step;

    assign locked  = cfg_q.en | busy;
    assign pa_step = cfg_q.pinc ? AW'(size_bytes(cfg_q.psize)) : '0;
    assign ma_step = cfg_q.minc ? AW'(size_bytes(cfg_q.msize)) : '0;

    // Register writes, per-item advance, reload and flag handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            pa_init  <= '0;
            ma_init  <= '0;
            pa_cur   <= '0;
            ma_cur   <= '0;
            cnt_init <= '0;
            cnt_cur  <= '0;
            tc_q     <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (flag_clr[0]) tc_q  <= 1'b0;
            if (flag_clr[1]) err_q <= 1'b0;
            if (wr_en && !locked) begin
                case (wr_sel)
                    SEL_CFG: begin
                        if (wr_data[0] && wr_data[2] && wr_data[3]) begin
                            cfg_q <= chan_cfg_t'({wr_data[CFG_W-1:1], 1'b0});
                            err_q <= 1'b1;
                        end else begin
                            cfg_q <= chan_cfg_t'(wr_data[CFG_W-1:0]);
                        end
                    end
                    SEL_PA: begin
                        pa_init <= wr_data[AW-1:0];
                        pa_cur  <= wr_data[AW-1:0];
                    end
                    SEL_MA: begin
                        ma_init <= wr_data[AW-1:0];
                        ma_cur  <= wr_data[AW-1:0];
                    end
                    default: begin
                        cnt_init <= wr_data[CW-1:0];
                        cnt_cur  <= wr_data[CW-1:0];
                    end
                endcase
            end else if (wr_en && cfg_q.en && wr_sel == SEL_CFG) begin
                cfg_q.en <= wr_data[0];
            end
            if (item_done) begin
                if (cnt_cur == CW'(1) && cfg_q.circ) begin
                    cnt_cur <= cnt_init;
                    pa_cur  <= pa_init;
                    ma_cur  <= ma_init;
                end else begin
                    cnt_cur <= cnt_cur - CW'(1);
                    pa_cur  <= pa_cur + pa_step;
                    ma_cur  <= ma_cur + ma_step;
                    if (cnt_cur == CW'(1)) tc_q <= 1'b1;
                end
            end
        end
    end

    assign cfg_o     = cfg_q;
    assign pa_cur_o  = pa_cur;
    assign ma_cur_o  = ma_cur;
    assign cnt_cur_o = cnt_cur;
    assign tc_o      = tc_q;
    assign err_o     = err_q;

endmodule

// File: rtl/dma_chan_engine.sv
// Item engine: waits for a start condition, reads one item from the source,
// then writes it to the destination, holding each bus phase until ready.
// Assumes source/destination addresses stay stable while an item is in flight.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          selftrig,
    input  logic          cnt_nz,
    input  logic          req,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [1:0]    src_size,
    input  logic [1:0]    dst_size,
    input  logic          bus_ready,
    input  logic [31:0]   bus_rdata,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [31:0]   bus_wdata,
    output logic          busy,
    output logic          item_done,
    output logic          ack
);
    eng_state_t  st, st_n;
    logic [31:0] data_q;
    logic [1:0]  raw_size;

    // Next-state selection for the read/write sequence
    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE:  if (run && cnt_nz && (selftrig || req)) st_n = ST_READ;
            ST_READ:  if (bus_ready) st_n = ST_WRITE;
            ST_WRITE: if (bus_ready) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // State register and captured, width-converted read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            data_q <= '0;
        end else begin
            st <= st_n;
            if (st == ST_READ && bus_ready)
                data_q <= bus_rdata & size_mask(src_size) & size_mask(dst_size);
        end
    end

    assign raw_size  = (st == ST_WRITE) ? dst_size : src_size;
    assign bus_valid = (st != ST_IDLE);
    assign bus_write = (st == ST_WRITE);
    assign bus_addr  = (st == ST_WRITE) ? dst_addr : src_addr;
    assign bus_size  = (raw_size == 2'b11) ? 2'b10 : raw_size;
    assign bus_wdata = data_q;
    assign busy      = (st != ST_IDLE);
    assign item_done = (st == ST_WRITE) && bus_ready;
    assign ack       = item_done && !selftrig;

endmodule

// File: rtl/dma_xfer_chan.sv
// Top of the single DMA channel: register file, direction mapping of the two
// address/size/increment triplets onto source and destination, item engine.
// Assumes a 32-bit data bus and one outstanding bus phase at a time.
module dma_xfer_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic [1:0]    reg_rsel,
    output logic [31:0]   reg_rdata,
    input  logic [1:0]    flag_clr,
    output logic          tc_flag,
    output logic          cfg_err,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [31:0]   bus_wdata,
    input  logic          bus_ready,
    input  logic [31:0]   bus_rdata
);
    chan_cfg_t     cfg_q;
    logic [AW-1:0] pa_cur, ma_cur, src_addr, dst_addr;
    logic [CW-1:0] cnt_cur;
    logic [1:0]    src_size, dst_size;
    logic          busy, item_done;

    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
        .flag_clr(flag_clr), .busy(busy), .item_done(item_done),
        .cfg_o(cfg_q), .pa_cur_o(pa_cur), .ma_cur_o(ma_cur),
        .cnt_cur_o(cnt_cur), .tc_o(tc_flag), .err_o(cfg_err)
    );

    // Direction mapping: dir=1 reads the memory side, dir=0 the peripheral side
    assign src_addr = cfg_q.dir ? ma_cur      : pa_cur;
    assign dst_addr = cfg_q.dir ? pa_cur      : ma_cur;
    assign src_size = cfg_q.dir ? cfg_q.msize : cfg_q.psize;
    assign dst_size = cfg_q.dir ? cfg_q.psize : cfg_q.msize;

    dma_chan_engine #(.AW(AW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .run(cfg_q.en), .selftrig(cfg_q.selftrig), .cnt_nz(cnt_cur != '0),
        .req(periph_req),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .src_size(src_size), .dst_size(dst_size),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .busy(busy), .item_done(item_done), .ack(periph_ack)
    );

    // Readback multiplexer
    always_comb begin
        case (reg_rsel)
            SEL_CFG: reg_rdata = 32'(cfg_q);
            SEL_PA:  reg_rdata = 32'(pa_cur);
            SEL_MA:  reg_rdata = 32'(ma_cur);
            default: reg_rdata = 32'(cnt_cur);
        endcase
    end

endmodule

// File: rtl/dma_xfer_chan_chk.sv
// Property checker for dma_xfer_chan, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module dma_xfer_chan_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_write,
    input logic          bus_ready,
    input logic [AW-1:0] bus_addr,
    input logic          periph_ack,
    input logic          tc_flag,
    input logic [1:0]    flag_clr,
    input logic          en,
    input logic          circ,
    input logic          selftrig,
    input logic [CW-1:0] cnt_cur
);
    p_hold_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

    p_no_bad_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && circ && selftrig));

    p_stop_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid && cnt_cur == '0 |=> !bus_valid);

    p_tc_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_flag && !flag_clr[0] |=> tc_flag);

    p_ack_paced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> bus_valid && bus_write && bus_ready && !selftrig);

    p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_write) |-> $past(bus_valid && !bus_write && bus_ready));

endmodule

bind dma_xfer_chan dma_xfer_chan_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .periph_ack(periph_ack),
    .tc_flag(tc_flag), .flag_clr(flag_clr),
    .en(cfg_q.en), .circ(cfg_q.circ), .selftrig(cfg_q.selftrig),
    .cnt_cur(cnt_cur)
);

// File: tb/sim_dma_xfer_chan.sv
`timescale 1ns/1ps
module sim_dma_xfer_chan;
    localparam logic [31:0] PA = 32'h4000_0100;
    localparam logic [31:0] MA = 32'h2000_0200;

    // Vector: [15:8] count, [7] selftrig, [6] minc, [5] pinc,
    //         [4:3] msize, [2:1] psize, [0] dir
    localparam logic [15:0] VEC [6] = '{
        {8'd4, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2, 1'b0},
        {8'd3, 1'b1, 1'b1, 1'b1, 2'd2, 2'd0, 1'b1},
        {8'd5, 1'b1, 1'b1, 1'b1, 2'd0, 2'd2, 1'b1},
        {8'd2, 1'b0, 1'b1, 1'b1, 2'd1, 2'd1, 1'b0},
        {8'd3, 1'b1, 1'b0, 1'b1, 2'd1, 2'd3, 1'b1},
        {8'd2, 1'b1, 1'b1, 1'b1, 2'd3, 2'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_rsel = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  flag_clr = '0;
    logic        tc_flag, cfg_err;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic        bus_valid, bus_write, bus_ready;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic        stall = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int log_n = 0;
    int cyc = 0;
    logic [31:0] log_addr [256];
    logic [31:0] log_data [256];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[15:0], a[15:0] ^ 16'h5A3C};
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] wmask(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    // Bus slave model: readable pattern, optional stall
    assign bus_ready = bus_valid & ~stall;
    assign bus_rdata = pat(bus_addr);

    dma_xfer_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .flag_clr(flag_clr), .tc_flag(tc_flag), .cfg_err(cfg_err),
        .periph_req(periph_req), .periph_ack(periph_ack),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    // Log of completed writes
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_valid && bus_write && bus_ready && log_n < 256) begin
            log_addr[log_n] <= bus_addr;
            log_data[log_n] <= bus_wdata;
            log_n <= log_n + 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_rsel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_clr(input logic [1:0] v);
        @(negedge clk); flag_clr = v;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic pulse_req(output bit seen);
        seen = 1'b0;
        @(negedge clk); periph_req = 1'b1;
        for (int k = 0; k < 50 && !seen; k++) begin
            @(negedge clk);
            if (periph_ack) seen = 1'b1;
        end
        periph_req = 1'b0;
    endtask

    task automatic run_vec(input logic [15:0] v);
        logic dir, pinc, minc, st;
        logic [1:0] ps, ms, ssz, dsz;
        logic [31:0] cfgw, sb, db, es, ed, rd;
        int cnt, base, after;
        bit seen, sinc, dinc;
        dir = v[0]; ps = v[2:1]; ms = v[4:3]; pinc = v[5]; minc = v[6];
        st = v[7]; cnt = int'(v[15:8]);
        cfgw = {22'd0, minc, pinc, ms, ps, st, 1'b0, dir, 1'b0};
        reg_write(2'd0, cfgw);
        reg_write(2'd1, PA);
        reg_write(2'd2, MA);
        reg_write(2'd3, 32'(cnt));
        base = log_n;
        reg_write(2'd0, cfgw | 32'd1);
        if (!st) begin
            for (int i = 0; i < cnt; i++) begin
                pulse_req(seen);
                check(seen, "R5 ack per request", 32'(seen), 32'd1);
            end
        end
        for (int k = 0; k < 200 && !tc_flag; k++) @(negedge clk);
        repeat (5) @(negedge clk);
        check(log_n - base == cnt, "R4/R5/R6 item count", 32'(log_n - base), 32'(cnt));
        check(tc_flag == 1'b1, "R6 tc sticky", 32'(tc_flag), 32'd1);
        sb = dir ? MA : PA;   db = dir ? PA : MA;
        ssz = dir ? ms : ps;  dsz = dir ? ps : ms;
        sinc = dir ? minc : pinc; dinc = dir ? pinc : minc;
        for (int i = 0; i < cnt && base + i < 256; i++) begin
            es = sb + (sinc ? 32'(i * nbytes(ssz)) : 32'd0);
            ed = db + (dinc ? 32'(i * nbytes(dsz)) : 32'd0);
            check(log_addr[base + i] == ed, "R2/R3 write address", log_addr[base + i], ed);
            check(log_data[base + i] == (pat(es) & wmask(ssz) & wmask(dsz)),
                  "R9/R3 write data", log_data[base + i], pat(es) & wmask(ssz) & wmask(dsz));
        end
        reg_read(2'd1, rd);
        check(rd == PA + (pinc ? 32'(cnt * nbytes(ps)) : 32'd0), "R2 final periph address",
              rd, PA + (pinc ? 32'(cnt * nbytes(ps)) : 32'd0));
        reg_read(2'd2, rd);
        check(rd == MA + (minc ? 32'(cnt * nbytes(ms)) : 32'd0), "R2 final memory address",
              rd, MA + (minc ? 32'(cnt * nbytes(ms)) : 32'd0));
        after = log_n;
        reg_write(2'd0, cfgw);
        pulse_clr(2'b01);
        check(tc_flag == 1'b0, "R6 tc cleared", 32'(tc_flag), 32'd0);
        check(log_n == after, "R6 no bus cycles after zero", 32'(log_n), 32'(after));
    endtask

    initial begin
        logic [31:0] rd, a0, cfgw;
        int base;
        bit seen;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        reg_read(2'd0, rd);
        check(rd == 32'd0, "R11 config after reset", rd, 32'd0);
        reg_read(2'd3, rd);
        check(rd == 32'd0, "R11 count after reset", rd, 32'd0);
        check(!tc_flag && !cfg_err && !bus_valid, "R11 flags and bus idle",
              {29'd0, tc_flag, cfg_err, bus_valid}, 32'd0);

        // Table walk
        foreach (VEC[i]) run_vec(VEC[i]);

        // R5 no start without request; R1 writes locked while enabled
        cfgw = {22'd0, 1'b1, 1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0};
        reg_write(2'd0, cfgw);
        reg_write(2'd1, PA);
        reg_write(2'd2, MA);
        reg_write(2'd3, 32'd3);
        base = log_n;
        reg_write(2'd0, cfgw | 32'd1);
        repeat (20) @(negedge clk);
        check(log_n == base, "R5 idle without request", 32'(log_n), 32'(base));
        reg_write(2'd1, 32'h0000_1234);
        reg_read(2'd1, rd);
        check(rd == PA, "R1 address write ignored while enabled", rd, PA);
        reg_write(2'd0, cfgw | 32'd3);
        reg_read(2'd0, rd);
        check(rd == (cfgw | 32'd1), "R1 config write ignored while enabled", rd, cfgw | 32'd1);
        pulse_req(seen);
        repeat (3) @(negedge clk);
        check(log_n - base == 1, "R5 one item per request", 32'(log_n - base), 32'd1);
        reg_read(2'd3, rd);
        check(rd == 32'd2, "R5 count after one request", rd, 32'd2);
        reg_write(2'd0, cfgw);
        reg_read(2'd0, rd);
        check(rd[0] == 1'b0, "R1 enable clear accepted", 32'(rd[0]), 32'd0);

        // R8 forbidden combination
        base = log_n;
        reg_write(2'd0, 32'h0000_000D);
        reg_read(2'd0, rd);
        check(rd[0] == 1'b0, "R8 enable refused", 32'(rd[0]), 32'd0);
        check(cfg_err == 1'b1, "R8 error flag", 32'(cfg_err), 32'd1);
        repeat (10) @(negedge clk);
        check(log_n == base && !bus_valid, "R8 no bus cycles", 32'(log_n), 32'(base));
        pulse_clr(2'b10);
        check(cfg_err == 1'b0, "R8 error cleared", 32'(cfg_err), 32'd0);

        // R7 circular wrap with pacing
        cfgw = {22'd0, 1'b1, 1'b1, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0};
        reg_write(2'd0, cfgw);
        reg_write(2'd1, PA);
        reg_write(2'd2, MA);
        reg_write(2'd3, 32'd2);
        base = log_n;
        reg_write(2'd0, cfgw | 32'd1);
        for (int i = 0; i < 3; i++) pulse_req(seen);
        repeat (3) @(negedge clk);
        check(log_n - base == 3, "R7 keeps running", 32'(log_n - base), 32'd3);
        check(log_addr[base + 2] == MA, "R7 address reloaded", log_addr[base + 2], MA);
        reg_read(2'd3, rd);
        check(rd == 32'd1, "R7 count reloaded", rd, 32'd1);
        reg_read(2'd1, rd);
        check(rd == PA + 32'd4, "R7 source address after wrap", rd, PA + 32'd4);
        check(tc_flag == 1'b0, "R7 no completion in circular", 32'(tc_flag), 32'd0);
        reg_write(2'd0, cfgw);

        // R10 abort during a stalled read; R12 phase held
        cfgw = {22'd0, 1'b1, 1'b1, 2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0};
        reg_write(2'd0, cfgw);
        reg_write(2'd1, PA);
        reg_write(2'd2, MA);
        reg_write(2'd3, 32'd10);
        base = log_n;
        @(negedge clk); stall = 1'b1;
        reg_write(2'd0, cfgw | 32'd1);
        @(negedge clk);
        a0 = bus_addr;
        check(bus_valid && !bus_write, "R12 read phase started", {30'd0, bus_valid, bus_write}, 32'd2);
        reg_write(2'd0, cfgw);
        repeat (3) @(negedge clk);
        check(bus_valid && !bus_write && bus_addr == a0, "R12 phase held under stall", bus_addr, a0);
        stall = 1'b0;
        repeat (20) @(negedge clk);
        check(log_n - base == 1, "R10 in-flight item finishes, no more", 32'(log_n - base), 32'd1);
        reg_read(2'd3, rd);
        check(rd == 32'd9, "R10 count after abort", rd, 32'd9);
        check(!bus_valid, "R10 bus idle after abort", 32'(bus_valid), 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule